// File: doc/BRIEF.md
# Modulo Interval Timer with Infrared Carrier Channel

This block holds three 8-bit count channels that share one count-enable strobe. Each channel counts up to a programmed modulo value and then restarts from zero. At that moment it sends a one-cycle interrupt pulse and flips an output level that can be routed to a pin. The result is a periodic interrupt together with a square wave of programmable frequency. The first two channels can be chained into a single 16-bit interval counter.

The third channel drives an infrared carrier. It has two modulo registers: one sets the length of the low phase and the other sets the length of the high phase. The channel reloads its compare value from whichever register matches the present output level. When remote mode is on, the carrier reaches the pin only while an envelope bit is set. Software writes the next envelope value into a buffer. The hardware moves that value into the active envelope only at the channel's own period boundary, so envelope edges always fall on carrier period boundaries.

Software programs the block through a small register port that uses one address for both writes and reads. Every count register can be read at any time.

Top module: `mt_timer_top`

## Requirements
- R1: With the run bit (control bit 0) set, each count-enable cycle advances a channel's count by one. The tick on which the count equals the modulo value returns the count to 0 instead. The interrupt for that channel is high for exactly the cycle that follows the tick.
- R2: Every modulo match flips the channel's output level. The pin shows that level while the output-enable bit (control bit 1) is 1 and is 0 otherwise. The level itself survives toggling of the enable bit.
- R3: Count registers read back at addresses 8, 9 and 10 for channels 0, 1 and 2. Reading never changes the count.
- R4: When the cascade bit (bit 2 of the control register at address 2) is 1, the following hold:
  - channel 0 runs from 0 through 255 and wraps;
  - channel 1 advances only on the tick where channel 0 wraps;
  - the pair clears, raises interrupt 0 and flips pin 0 only when both halves equal their modulo registers (addresses 1 and 3);
  - interrupt 1 stays 0.
- R5: When the cascade bit is 0, channels 0 and 1 count independently, each against its own modulo value.
- R6: The carrier channel starts at the low level. During the low phase it compares against the low-period register (address 5), and during the high phase against the high-period register (address 6). A phase therefore lasts that value plus one ticks.
- R7: With remote mode (bit 2 of the carrier control at address 4) set, the carrier pin is high only when the active envelope is 1. With remote mode clear, the pin follows the carrier level.
- R8: The envelope buffer (carrier control bit 3) is copied into the active envelope (read-only bit 4) only on a carrier match. Until that match, the pin and the active bit keep their previous value.
- R9: Reset clears every count, output level, control bit, modulo register, envelope bit and pending interrupt.
- R10: Clearing a channel's run bit forces its count to 0 and holds it there. The output level is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for writes and reads |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data for the register at addr |
| cnt_en | input | 1 | Prescaled count-clock enable, one tick per high cycle |
| irq | output | 3 | One-cycle interrupt pulse per channel |
| pin | output | 3 | Gated output level per channel |

## Verification
The hardest case to reach is the 16-bit cascade match. Its lower half already equals its modulo value on the second tick, long before the upper half matches. To reach it, the bench programs the lower modulo to 2 and the upper modulo to 1, then lets 259 ticks run without a break. Along the way it checks three things: the false match at tick 2, the carry at the wrap of the lower half, and the true match. For the envelope buffer, the bench pauses counting in mid-carrier and rewrites the buffer. It then confirms that the pin and the active bit do not move until the next carrier match.

// File: rtl/mt_pkg.sv
package mt_pkg;
   localparam int unsigned AW = 4;
   localparam logic [AW-1:0] A_C0_CTRL = 4'd0;
   localparam logic [AW-1:0] A_C0_MOD  = 4'd1;
   localparam logic [AW-1:0] A_C1_CTRL = 4'd2;
   localparam logic [AW-1:0] A_C1_MOD  = 4'd3;
   localparam logic [AW-1:0] A_CR_CTRL = 4'd4;
   localparam logic [AW-1:0] A_CR_LO   = 4'd5;
   localparam logic [AW-1:0] A_CR_HI   = 4'd6;
   localparam logic [AW-1:0] A_C0_CNT  = 4'd8;
   localparam logic [AW-1:0] A_C1_CNT  = 4'd9;
   localparam logic [AW-1:0] A_CR_CNT  = 4'd10;
   localparam int unsigned B_RUN  = 0;
   localparam int unsigned B_OE   = 1;
   localparam int unsigned B_CASC = 2;
   localparam int unsigned B_REM  = 2;
   localparam int unsigned B_ENVB = 3;
   localparam int unsigned B_ENV  = 4;
   localparam int unsigned CTRL_MSB = 4;
endpackage

// File: rtl/mt_count.sv
module mt_count #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   if (W < 2) begin : g_bad_w
      $error("mt_count: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (clr)       cnt <= '0;
      else if (tick)      cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mt_pair.sv
module mt_pair #(
   parameter int unsigned W          = 8,
   parameter bit          CASCADE_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_en,
   input  logic         run0,
   input  logic         oe0,
   input  logic         run1,
   input  logic         oe1,
   input  logic         casc,
   input  logic [W-1:0] m0,
   input  logic [W-1:0] m1,
   output logic [W-1:0] c0,
   output logic [W-1:0] c1,
   output logic         irq0,
   output logic         irq1,
   output logic         pin0,
   output logic         pin1
);
   logic casc_on, tick0, tick1, run1e, clr0, clr1, ev1, hit16, lvl0, lvl1;

   if (CASCADE_EN) begin : g_casc
      assign casc_on = casc;
   end else begin : g_solo
      assign casc_on = 1'b0;
   end

   assign tick0 = cnt_en & run0;
   assign hit16 = tick0 & (c0 == m0) & (c1 == m1);
   assign clr0  = casc_on ? hit16 : (tick0 & (c0 == m0));
   assign run1e = casc_on ? run0 : run1;
   assign tick1 = casc_on ? (tick0 & (&c0)) : (cnt_en & run1);
   assign clr1  = casc_on ? hit16 : (tick1 & (c1 == m1));
   assign ev1   = ~casc_on & clr1;

   mt_count #(.W(W)) u_lo (.clk(clk), .rst_n(rst_n), .run(run0),  .tick(tick0), .clr(clr0), .cnt(c0));
   mt_count #(.W(W)) u_hi (.clk(clk), .rst_n(rst_n), .run(run1e), .tick(tick1), .clr(clr1), .cnt(c1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq0 <= 1'b0; irq1 <= 1'b0; lvl0 <= 1'b0; lvl1 <= 1'b0;
      end else begin
         irq0 <= clr0;
         irq1 <= ev1;
         lvl0 <= lvl0 ^ clr0;
         lvl1 <= lvl1 ^ ev1;
      end
   end

   assign pin0 = oe0 & lvl0;
   assign pin1 = oe1 & lvl1;

   a_r1_irq_zero: assert property (@(posedge clk) disable iff (!rst_n)
      irq0 |-> (c0 == '0));
   a_r2_pin_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (oe0 && $past(oe0) && (pin0 != $past(pin0))) |-> irq0);
   a_r4_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (casc_on && $past(casc_on)) |-> !irq1);
endmodule

// File: rtl/mt_carrier.sv
module mt_carrier #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_en,
   input  logic         run,
   input  logic         oe,
   input  logic         rem,
   input  logic         envb,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic [W-1:0] c,
   output logic         irq,
   output logic         pin,
   output logic         env
);
   logic         lvl, tick, hit;
   logic [W-1:0] cmp;

   assign cmp  = lvl ? hi : lo;
   assign tick = cnt_en & run;
   assign hit  = tick & (c == cmp);

   mt_count #(.W(W)) u_cnt (.clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .clr(hit), .cnt(c));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq <= 1'b0; lvl <= 1'b0; env <= 1'b0;
      end else begin
         irq <= hit;
         lvl <= lvl ^ hit;
         if (hit) env <= envb;
      end
   end

   assign pin = oe & lvl & (~rem | env);

   a_r8_env_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (env != $past(env)) |-> irq);
   a_r6_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (c == '0));
endmodule

// File: rtl/mt_timer_top.sv
module mt_timer_top
   import mt_pkg::*;
#(
   parameter int unsigned W          = 8,
   parameter bit          CASCADE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wr_data,
   output logic [W-1:0]  rd_data,
   input  logic          cnt_en,
   output logic [2:0]    irq,
   output logic [2:0]    pin
);
   localparam int unsigned NCH = 3;

   if (W <= CTRL_MSB) begin : g_bad_w
      $error("mt_timer_top: W too narrow for control fields");
   end

   logic         run0, oe0, run1, oe1, casc, runc, oec, remc, envb, env;
   logic [W-1:0] m0, m1, lo, hi, c0, c1, cc;
   logic [NCH-1:0] irq_v, pin_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {run0, oe0, run1, oe1, casc, runc, oec, remc, envb} <= '0;
         m0 <= '0; m1 <= '0; lo <= '0; hi <= '0;
      end else if (wr_en) begin
         case (addr)
            A_C0_CTRL: begin run0 <= wr_data[B_RUN]; oe0 <= wr_data[B_OE]; end
            A_C0_MOD:  m0 <= wr_data;
            A_C1_CTRL: begin
               run1 <= wr_data[B_RUN]; oe1 <= wr_data[B_OE]; casc <= wr_data[B_CASC];
            end
            A_C1_MOD:  m1 <= wr_data;
            A_CR_CTRL: begin
               runc <= wr_data[B_RUN]; oec <= wr_data[B_OE];
               remc <= wr_data[B_REM]; envb <= wr_data[B_ENVB];
            end
            A_CR_LO:   lo <= wr_data;
            A_CR_HI:   hi <= wr_data;
            default:   ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (addr)
         A_C0_CTRL: begin rd_data[B_RUN] = run0; rd_data[B_OE] = oe0; end
         A_C0_MOD:  rd_data = m0;
         A_C1_CTRL: begin
            rd_data[B_RUN] = run1; rd_data[B_OE] = oe1; rd_data[B_CASC] = casc;
         end
         A_C1_MOD:  rd_data = m1;
         A_CR_CTRL: begin
            rd_data[B_RUN] = runc; rd_data[B_OE] = oec; rd_data[B_REM] = remc;
            rd_data[B_ENVB] = envb; rd_data[B_ENV] = env;
         end
         A_CR_LO:   rd_data = lo;
         A_CR_HI:   rd_data = hi;
         A_C0_CNT:  rd_data = c0;
         A_C1_CNT:  rd_data = c1;
         A_CR_CNT:  rd_data = cc;
         default:   rd_data = '0;
      endcase
   end

   mt_pair #(.W(W), .CASCADE_EN(CASCADE_EN)) u_pair (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
      .run0(run0), .oe0(oe0), .run1(run1), .oe1(oe1), .casc(casc),
      .m0(m0), .m1(m1), .c0(c0), .c1(c1),
      .irq0(irq_v[0]), .irq1(irq_v[1]), .pin0(pin_v[0]), .pin1(pin_v[1])
   );

   mt_carrier #(.W(W)) u_car (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
      .run(runc), .oe(oec), .rem(remc), .envb(envb), .lo(lo), .hi(hi),
      .c(cc), .irq(irq_v[2]), .pin(pin_v[2]), .env(env)
   );

   assign irq = irq_v;
   assign pin = pin_v;

   a_r9_quiet_after_reset: assert property (@(posedge clk)
      $past(!rst_n) |-> (irq == '0));
endmodule

// File: tb/mt_timer_top_tb_top.sv
module mt_timer_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         cnt_en = 1'b0;
   logic [2:0]   irq, pin;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int          sel;
      int          idx;
      logic [7:0]  exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mt_timer_top #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .cnt_en(cnt_en), .irq(irq), .pin(pin)
   );

   // monitor: pops expected items and compares them with the design outputs
   always @(negedge clk) begin
      #1;
      while (sb_q.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = sb_q.pop_front();
         case (it.sel)
            0:       act = rd_data;
            1:       act = {7'd0, pin[it.idx]};
            default: act = {7'd0, irq[it.idx]};
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s sel=%0d idx=%0d actual=%0h expected=%0h", it.tag, it.sel, it.idx, act, it.exp);
         end
      end
   end

   task automatic push(int sel, int idx, logic [7:0] exp, string tag);
      item_t it;
      it.sel = sel; it.idx = idx; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic rd_here(logic [3:0] a, logic [7:0] exp, string tag);
      addr = a;
      push(0, 0, exp, tag);
   endtask

   task automatic rd_now(logic [3:0] a, logic [7:0] exp, string tag);
      @(negedge clk);
      rd_here(a, exp, tag);
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0; addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R9 reset state
      do_reset();
      for (int i = 0; i < 3; i++) begin
         push(1, i, 0, "R9 pin after reset");
         push(2, i, 0, "R9 irq after reset");
      end
      rd_now(4'd8, 0, "R9 count0 after reset");
      rd_now(4'd4, 0, "R9 carrier ctrl after reset");
      rd_now(4'd10, 0, "R9 carrier count after reset");

      // R1 R2 R3 R5: independent channels, ch0 modulo 3, ch1 modulo 1
      wr(4'd1, 8'd3); wr(4'd0, 8'h03); wr(4'd3, 8'd1); wr(4'd2, 8'h03);
      cnt_en = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         if (k == 2) begin push(2, 1, 1, "R5 irq1 at tick 2"); push(1, 1, 1, "R5 pin1 high"); end
         if (k == 3) begin rd_here(4'd8, 3, "R3 count0 readback"); push(2, 0, 0, "R1 no irq before match"); end
         if (k == 4) begin
            push(2, 0, 1, "R1 irq0 after match"); push(1, 0, 1, "R2 pin0 toggled");
            rd_here(4'd8, 0, "R1 count0 wrapped"); push(2, 1, 1, "R5 irq1 second period");
         end
         if (k == 5) begin push(2, 0, 0, "R1 irq0 single pulse"); rd_here(4'd8, 1, "R3 count0 after wrap"); end
      end
      cnt_en = 1'b0;
      wr(4'd0, 8'h01); push(1, 0, 0, "R2 pin0 gated off");
      wr(4'd0, 8'h03); push(1, 0, 1, "R2 pin0 level kept");
      rd_now(4'd8, 1, "R3 read leaves count");
      rd_now(4'd8, 1, "R3 repeated read");
      wr(4'd0, 8'h02);
      rd_now(4'd8, 0, "R10 stop clears count");
      push(1, 0, 1, "R10 level kept when stopped");

      // R4 cascade: low modulo 2, high modulo 1 -> match at tick 259
      do_reset();
      wr(4'd1, 8'd2); wr(4'd3, 8'd1); wr(4'd2, 8'h04); wr(4'd0, 8'h03);
      cnt_en = 1'b1;
      for (int k = 1; k <= 260; k++) begin
         @(negedge clk);
         if (k == 2)   begin push(2, 0, 0, "R4 low half alone no irq"); rd_here(4'd8, 2, "R4 low passes match"); end
         if (k == 3)   push(2, 0, 0, "R4 still no irq");
         if (k == 255) rd_here(4'd9, 0, "R4 upper before carry");
         if (k == 256) rd_here(4'd9, 1, "R4 upper after carry");
         if (k == 257) rd_here(4'd8, 1, "R4 low after wrap");
         if (k == 258) push(2, 0, 0, "R4 no irq before full match");
         if (k == 259) begin
            push(2, 0, 1, "R4 irq on full match"); push(1, 0, 1, "R4 pin0 toggled");
            rd_here(4'd9, 0, "R4 upper cleared"); push(2, 1, 0, "R4 irq1 silent");
         end
         if (k == 260) rd_here(4'd8, 1, "R4 restart after match");
      end
      cnt_en = 1'b0;

      // R6 R7 R8 carrier: low 2, high 1, run|oe|remote|envbuf
      do_reset();
      wr(4'd5, 8'd2); wr(4'd6, 8'd1); wr(4'd4, 8'h0F);
      cnt_en = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (k == 2) begin push(1, 2, 0, "R7 envelope not yet active"); rd_here(4'd10, 2, "R6 low phase count"); end
         if (k == 3) begin push(2, 2, 1, "R6 low phase ends"); push(1, 2, 1, "R8 envelope loaded at match"); end
         if (k == 4) push(1, 2, 1, "R6 high phase lasting");
         if (k == 5) begin push(1, 2, 0, "R6 high phase ends"); push(2, 2, 1, "R6 irq at high end"); end
         if (k == 7) begin push(2, 2, 0, "R6 no irq mid low"); rd_here(4'd10, 2, "R6 low count again"); end
         if (k == 8) begin push(2, 2, 1, "R6 low end again"); push(1, 2, 1, "R6 high again"); end
      end
      cnt_en = 1'b0;
      wr(4'd4, 8'h07); push(1, 2, 1, "R8 buffer write not yet active");
      rd_now(4'd4, 8'h17, "R8 active bit kept buffer cleared");
      cnt_en = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         if (k == 2) begin push(1, 2, 0, "R8 envelope drops at match"); push(2, 2, 1, "R8 match"); end
         if (k == 5) begin push(2, 2, 1, "R7 carrier high again"); push(1, 2, 0, "R7 pin held low"); end
      end
      cnt_en = 1'b0;
      wr(4'd4, 8'h03); push(1, 2, 1, "R7 remote off pin follows carrier");
      rd_now(4'd4, 8'h03, "R8 active envelope cleared");
      wr(4'd4, 8'h01); push(1, 2, 0, "R2 carrier oe off");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule